// File: doc/BRIEF.md
# Circular Byte FIFO with Last-Operation Status

This block carries bytes from a producer, such as a receive handler, to a consumer, such as a main loop. Both sides share one clock. The producer pulses a put strobe with a data byte. The consumer pulses a get strobe and receives the oldest stored byte on the next cycle.

Storage is a fixed ring of entries. A write index advances on each accepted put, and a read index advances on each accepted get. Both indices wrap back to entry zero after the last entry. The block keeps no occupancy counter and no extra index bit. When the two indices match, a one-bit record of the most recent lone operation decides the meaning. If that operation was a get, the ring is empty. If it was a put, the ring is full, which is reported as overflow.

Top module: `byte_ring_fifo`

## Requirements
- R1: Bytes come out on `get_data_o` in the order they were accepted by puts. Data moves only from the put side to the get side.
- R2: The write index moves only on an accepted put. The read index moves only on an accepted get. The bench observes this through the order and content of the data read out.
- R3: Both indices return to entry 0 after entry DEPTH-1, for any DEPTH, including values that are not a power of two.
- R4: `empty_o` is 1 exactly when the indices are equal after a get, or after reset. This is the state in which the number of stored bytes is zero.
- R5: `ovf_o` is 1 exactly when the indices became equal through a put, meaning DEPTH bytes are stored. `empty_o` and `ovf_o` are never 1 together.
- R6: A synchronous active-high `rst` leaves the ring empty: `empty_o`=1, `ovf_o`=0, `get_data_o`=0.
- R7: A get while `empty_o`=1 is ignored. No index moves, and `get_data_o` keeps its value.
- R8: A put while `ovf_o`=1 is rejected. The byte is dropped, and `ovf_o` stays 1 unless a get is accepted in the same cycle.
- R9: A put and a get in the same cycle, with neither flag set, both take effect. The stored count and both flags are left unchanged.
- R10: The byte for an accepted get appears on `get_data_o` in the cycle after the get strobe.
- R11: `get_data_o` holds its last value in every cycle that follows no accepted get.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by producer and consumer |
| rst | input | 1 | Synchronous active-high reset |
| put_i | input | 1 | Producer write strobe |
| put_data_i | input | WIDTH | Byte to store |
| get_i | input | 1 | Consumer read strobe |
| get_data_o | output | WIDTH | Registered read byte, valid the cycle after an accepted get |
| empty_o | output | 1 | Indices equal after a get or reset |
| ovf_o | output | 1 | Indices equal after a put (ring full) |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default 16 entries of 8 bits. The other uses 5 entries, where the index wrap cannot rely on natural binary rollover, so the explicit wrap compare of R3 is exercised. The small copy also reaches the full and empty boundaries every few cycles under random traffic. As a result, rejected puts, ignored gets and simultaneous operations at both boundaries occur many times.

// File: rtl/byte_ring_pkg.sv
package byte_ring_pkg;
  typedef enum logic {
    OP_GET = 1'b0,
    OP_PUT = 1'b1
  } last_op_e;
endpackage

// File: rtl/ring_index.sv
module ring_index #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] idx_o,
  output logic [AW-1:0] idx_nxt_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [AW-1:0] idx_q;
  logic [AW-1:0] inc;

  generate
    if (POW2) begin : g_natural
      assign inc = idx_q + 1'b1;
    end else begin : g_compare
      assign inc = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  endgenerate

  assign idx_nxt_o = adv ? inc : idx_q;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_nxt_o;
  end

  assign idx_o = idx_q;

  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && idx_q == LAST) |=> (idx_q == '0));

  p_hold_without_adv_r2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(idx_q));
endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  p_no_same_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (we && re) |-> (waddr != raddr));

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/op_tracker.sv
module op_tracker
  import byte_ring_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          put_acc,
  input  logic          get_acc,
  input  logic [AW-1:0] widx_nxt,
  input  logic [AW-1:0] ridx_nxt,
  output logic          empty_o,
  output logic          ovf_o
);
  last_op_e last_q, last_nxt;
  logic     same_nxt;

  always_comb begin
    last_nxt = last_q;
    if (put_acc && !get_acc)      last_nxt = OP_PUT;
    else if (get_acc && !put_acc) last_nxt = OP_GET;
  end

  assign same_nxt = (widx_nxt == ridx_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= OP_GET;
      empty_o <= 1'b1;
      ovf_o   <= 1'b0;
    end else begin
      last_q  <= last_nxt;
      empty_o <= same_nxt && (last_nxt == OP_GET);
      ovf_o   <= same_nxt && (last_nxt == OP_PUT);
    end
  end

  p_both_keep_record_r9: assert property (@(posedge clk) disable iff (rst)
    (put_acc && get_acc) |=> $stable(last_q));
endmodule

// File: rtl/byte_ring_fifo.sv
module byte_ring_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             put_i,
  input  logic [WIDTH-1:0] put_data_i,
  input  logic             get_i,
  output logic [WIDTH-1:0] get_data_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          put_acc, get_acc;
  logic [AW-1:0] widx, ridx, widx_nxt, ridx_nxt;

  assign put_acc = put_i && !ovf_o;
  assign get_acc = get_i && !empty_o;

  ring_index #(.DEPTH(DEPTH), .AW(AW)) u_widx (
    .clk(clk), .rst(rst), .adv(put_acc), .idx_o(widx), .idx_nxt_o(widx_nxt)
  );

  ring_index #(.DEPTH(DEPTH), .AW(AW)) u_ridx (
    .clk(clk), .rst(rst), .adv(get_acc), .idx_o(ridx), .idx_nxt_o(ridx_nxt)
  );

  ring_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst),
    .we(put_acc), .waddr(widx), .wdata(put_data_i),
    .re(get_acc), .raddr(ridx), .rdata(get_data_o)
  );

  op_tracker #(.AW(AW)) u_track (
    .clk(clk), .rst(rst), .put_acc(put_acc), .get_acc(get_acc),
    .widx_nxt(widx_nxt), .ridx_nxt(ridx_nxt),
    .empty_o(empty_o), .ovf_o(ovf_o)
  );

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(empty_o && ovf_o));

  p_empty_from_get_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_o) |-> $past(get_i));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(put_i));

  p_get_empty_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (get_i && empty_o) |=> (ridx == $past(ridx)));

  p_put_full_rejected_r8: assert property (@(posedge clk) disable iff (rst)
    (put_i && ovf_o && !get_i) |=> (ovf_o && widx == $past(widx)));

  p_flags_match_equal_r4: assert property (@(posedge clk) disable iff (rst)
    (empty_o || ovf_o) |-> (widx == ridx));
endmodule

// File: tb/byte_ring_fifo_bench.sv
module byte_ring_fifo_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic put = 1'b0, get = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] rd_a, rd_b;
  logic emp_a, ovf_a, emp_b, ovf_b;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string phase = "R6";

  logic [7:0] qa[$];
  logic [7:0] qb[$];
  logic [7:0] exp_a = '0, exp_b = '0;

  always #2 clk = ~clk;

  byte_ring_fifo #(.DEPTH(16), .WIDTH(8)) u_byte_ring_fifo (
    .clk(clk), .rst(rst), .put_i(put), .put_data_i(din), .get_i(get),
    .get_data_o(rd_a), .empty_o(emp_a), .ovf_o(ovf_a)
  );

  byte_ring_fifo #(.DEPTH(5), .WIDTH(8)) u_small (
    .clk(clk), .rst(rst), .put_i(put), .put_data_i(din), .get_i(get),
    .get_data_o(rd_b), .empty_o(emp_b), .ovf_o(ovf_b)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (phase %s) %s: actual %0d expected %0d",
               tag, phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(emp_a === (qa.size() == 0), "R4", "empty d16", int'(emp_a), int'(qa.size() == 0));
    chk(ovf_a === (qa.size() == 16), "R5", "ovf d16", int'(ovf_a), int'(qa.size() == 16));
    chk(rd_a === exp_a, "R1", "data d16", int'(rd_a), int'(exp_a));
    chk(emp_b === (qb.size() == 0), "R4", "empty d5", int'(emp_b), int'(qb.size() == 0));
    chk(ovf_b === (qb.size() == 5), "R5", "ovf d5", int'(ovf_b), int'(qb.size() == 5));
    chk(rd_b === exp_b, "R10", "data d5", int'(rd_b), int'(exp_b));
  endtask

  task automatic step(input logic p, input logic g, input logic [7:0] d);
    bit pa, ga, pb, gb;
    put = p; get = g; din = d;
    pa = p && (qa.size() < 16);
    ga = g && (qa.size() > 0);
    if (ga) exp_a = qa.pop_front();
    if (pa) qa.push_back(d);
    pb = p && (qb.size() < 5);
    gb = g && (qb.size() > 0);
    if (gb) exp_b = qb.pop_front();
    if (pb) qb.push_back(d);
    @(posedge clk);
    @(negedge clk);
    put = 1'b0; get = 1'b0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R6";
    chk(emp_a === 1'b1, "R6", "empty after reset", int'(emp_a), 1);
    chk(ovf_a === 1'b0, "R6", "ovf after reset", int'(ovf_a), 0);
    chk(rd_a === 8'h00, "R6", "data after reset", int'(rd_a), 0);

    phase = "R7";
    step(1'b0, 1'b1, 8'h00);
    step(1'b0, 1'b1, 8'h00);

    phase = "R3";
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 8'(8'h40 + i));
    phase = "R8";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'hEE);
    chk(ovf_a === 1'b1, "R8", "ovf stays after rejected puts", int'(ovf_a), 1);
    phase = "R2";
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 8'h00);
    phase = "R11";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h11);
    phase = "R7";
    step(1'b0, 1'b1, 8'h00);
    chk(rd_a === 8'h4F, "R7", "data kept after empty get", int'(rd_a), 8'h4F);

    phase = "R9";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'(8'h80 + i));
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 8'(8'h90 + i));
    phase = "R3";
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 8'h00);

    phase = "R10";
    for (int i = 0; i < 3000; i++) begin
      int bias = (i / 200) % 3;
      int r = int'($urandom_range(0, 99));
      int s = int'($urandom_range(0, 99));
      logic p = (bias == 0) ? (r < 75) : (bias == 1) ? (r < 25) : (r < 50);
      logic g = (bias == 0) ? (s < 25) : (bias == 1) ? (s < 75) : (s < 50);
      step(p, g, 8'($urandom_range(0, 255)));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule